// File: doc/BRIEF.md
# Register Rename Table with Result Writeback

This block keeps the architectural register file of an out-of-order core together with a rename table that records, for every register, whether its newest value already sits in the register file or is still to be produced by a reservation station. Each register's rename entry is a valid bit plus a binary station tag. When valid is 1, the register is renamed and the tag names the station that will produce its value.

On the issue port, one instruction per cycle presents two source registers, a destination register and the tag of the station allocated to it. The block returns each source as either a value or a producer tag, and it records the new tag against the destination register. On the broadcast port, a finished station presents its tag and result. Every register still mapped to that tag takes the value into the register file and drops its mapping in the same clock edge.

An issue and a broadcast in the same cycle are both accepted. When they touch the same register, the issue's mapping is the one that remains. A source that a same-cycle broadcast is resolving receives the broadcast value directly instead of a tag that is about to vanish.

Top module: `alias_map`

## Requirements
- R1: After reset every register reads back as a value (is_tag 0) equal to zero, and res_valid is 0.
- R2: A source register that is not renamed returns is_tag 0 and its register-file value.
- R3: A source register that is renamed returns is_tag 1 and the stored tag, given as the binary station index.
- R4: An accepted issue maps the destination register to iss_tag, and later issues read that tag for it.
- R5: A broadcast whose tag equals a register's stored tag writes bc_value into that register and clears its mapping on the same edge, so the next read returns the value.
- R6: A broadcast whose tag matches no valid mapping changes neither any mapping nor any register value.
- R7: When an issue renames the register that a same-cycle broadcast clears, the register stays mapped to the issue's tag.
- R8: A source register cleared by a same-cycle broadcast returns is_tag 0 and bc_value.
- R9: Operand results are registered: res_valid and the operands appear on the cycle after iss_valid, and res_valid is 0 on the cycle after a cycle without an issue.
- R10: Sources are resolved against the mapping held before the same instruction's destination update, so a source equal to the destination does not see the new tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue request this cycle |
| iss_src_a | input | 3 | First source register index |
| iss_src_b | input | 3 | Second source register index |
| iss_dst | input | 3 | Destination register index |
| iss_tag | input | 2 | Station tag allocated to the issued instruction |
| bc_valid | input | 1 | Result broadcast this cycle |
| bc_tag | input | 2 | Tag of the broadcasting station |
| bc_value | input | 32 | Broadcast result |
| res_valid | output | 1 | Operand results valid |
| opa_is_tag | output | 1 | First operand is a tag (1) or a value (0) |
| opa_tag | output | 2 | First operand tag, zero when a value |
| opa_value | output | 32 | First operand value, zero when a tag |
| opb_is_tag | output | 1 | Second operand is a tag (1) or a value (0) |
| opb_tag | output | 2 | Second operand tag, zero when a value |
| opb_value | output | 32 | Second operand value, zero when a tag |

## Verification
Operand results are due one cycle after the issue: inputs are applied at a falling edge, the rising edge captures them, and the bench reads the outputs at the next falling edge. Mapping and register-file updates from an issue or broadcast take effect on that same rising edge, so they are seen by an issue made in the following cycle and read one cycle after that. Each scenario task follows this two-step pattern: stimulus, then a probing issue, then a check at the falling edge after the probe. Valid inputs are dropped right after the capturing edge, so that no stimulus is applied twice.

// File: rtl/alias_pkg.sv
package alias_pkg;
  localparam int DEF_NREG = 8;
  localparam int DEF_NTAG = 4;
  localparam int DEF_DW   = 32;

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/alias_rename_table.sv
module alias_rename_table #(
  parameter int NREG = 8,
  parameter int NTAG = 4,
  parameter int RW   = 3,
  parameter int TW   = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      iss_we,
  input  logic [RW-1:0]             iss_dst,
  input  logic [TW-1:0]             iss_tag,
  input  logic                      bc_valid,
  input  logic [TW-1:0]             bc_tag,
  output logic [NREG-1:0]           map_vld,
  output logic [NREG-1:0][TW-1:0]   map_tag,
  output logic [NREG-1:0]           clr_hit
);
  localparam int TAG_SPACE = NTAG;

  for (genvar r = 0; r < NREG; r++) begin : g_ent
    logic take_issue;
    assign take_issue = iss_we && (iss_dst == RW'(r));
    assign clr_hit[r] = bc_valid && map_vld[r] && (map_tag[r] == bc_tag);

    always_ff @(posedge clk) begin
      if (rst) begin
        map_vld[r] <= 1'b0;
        map_tag[r] <= '0;
      end else if (take_issue) begin
        // the issue update wins over a same-cycle clear
        map_vld[r] <= 1'b1;
        map_tag[r] <= iss_tag;
      end else if (clr_hit[r]) begin
        map_vld[r] <= 1'b0;
      end
    end
  end

  if (TAG_SPACE < 1) begin : g_bad
    initial $display("alias_rename_table: NTAG must be at least 1");
  end
endmodule

// File: rtl/alias_regfile.sv
module alias_regfile #(
  parameter int NREG = 8,
  parameter int DW   = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NREG-1:0]         wr_mask,
  input  logic [DW-1:0]           wr_data,
  output logic [NREG-1:0][DW-1:0] rf_q
);
  for (genvar r = 0; r < NREG; r++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)             rf_q[r] <= '0;
      else if (wr_mask[r]) rf_q[r] <= wr_data;
    end
  end
endmodule

// File: rtl/alias_operand_resolve.sv
module alias_operand_resolve #(
  parameter int NREG = 8,
  parameter int DW   = 32,
  parameter int RW   = 3,
  parameter int TW   = 2
) (
  input  logic [RW-1:0]             src,
  input  logic [NREG-1:0]           map_vld,
  input  logic [NREG-1:0][TW-1:0]   map_tag,
  input  logic [NREG-1:0]           clr_hit,
  input  logic [NREG-1:0][DW-1:0]   rf_q,
  input  logic [DW-1:0]             bc_value,
  output logic                      is_tag,
  output logic [TW-1:0]             tag,
  output logic [DW-1:0]             val
);
  always_comb begin
    is_tag = 1'b0;
    tag    = '0;
    val    = rf_q[src];
    if (clr_hit[src]) begin
      val = bc_value;               // bypass the value being written now
    end else if (map_vld[src]) begin
      is_tag = 1'b1;
      tag    = map_tag[src];
      val    = '0;
    end
  end
endmodule

// File: rtl/alias_map.sv
module alias_map
  import alias_pkg::*;
#(
  parameter int NREG = DEF_NREG,
  parameter int NTAG = DEF_NTAG,
  parameter int DW   = DEF_DW,
  parameter int RW   = idx_w(NREG),
  parameter int TW   = idx_w(NTAG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          iss_valid,
  input  logic [RW-1:0] iss_src_a,
  input  logic [RW-1:0] iss_src_b,
  input  logic [RW-1:0] iss_dst,
  input  logic [TW-1:0] iss_tag,
  input  logic          bc_valid,
  input  logic [TW-1:0] bc_tag,
  input  logic [DW-1:0] bc_value,
  output logic          res_valid,
  output logic          opa_is_tag,
  output logic [TW-1:0] opa_tag,
  output logic [DW-1:0] opa_value,
  output logic          opb_is_tag,
  output logic [TW-1:0] opb_tag,
  output logic [DW-1:0] opb_value
);
  localparam int NSRC = 2;

  logic [NREG-1:0]           map_vld;
  logic [NREG-1:0][TW-1:0]   map_tag;
  logic [NREG-1:0]           clr_hit;
  logic [NREG-1:0][DW-1:0]   rf_q;

  logic [NSRC-1:0][RW-1:0]   src_idx;
  logic [NSRC-1:0]           r_is_tag, q_is_tag;
  logic [NSRC-1:0][TW-1:0]   r_tag, q_tag;
  logic [NSRC-1:0][DW-1:0]   r_val, q_val;

  assign src_idx[0] = iss_src_a;
  assign src_idx[1] = iss_src_b;

  alias_rename_table #(.NREG(NREG), .NTAG(NTAG), .RW(RW), .TW(TW)) u_table (
    .clk(clk), .rst(rst),
    .iss_we(iss_valid), .iss_dst(iss_dst), .iss_tag(iss_tag),
    .bc_valid(bc_valid), .bc_tag(bc_tag),
    .map_vld(map_vld), .map_tag(map_tag), .clr_hit(clr_hit)
  );

  alias_regfile #(.NREG(NREG), .DW(DW)) u_rf (
    .clk(clk), .rst(rst),
    .wr_mask(clr_hit), .wr_data(bc_value), .rf_q(rf_q)
  );

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    alias_operand_resolve #(.NREG(NREG), .DW(DW), .RW(RW), .TW(TW)) u_res (
      .src(src_idx[s]), .map_vld(map_vld), .map_tag(map_tag),
      .clr_hit(clr_hit), .rf_q(rf_q), .bc_value(bc_value),
      .is_tag(r_is_tag[s]), .tag(r_tag[s]), .val(r_val[s])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        q_is_tag[s] <= 1'b0;
        q_tag[s]    <= '0;
        q_val[s]    <= '0;
      end else if (iss_valid) begin
        q_is_tag[s] <= r_is_tag[s];
        q_tag[s]    <= r_tag[s];
        q_val[s]    <= r_val[s];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) res_valid <= 1'b0;
    else     res_valid <= iss_valid;
  end

  assign opa_is_tag = q_is_tag[0];
  assign opa_tag    = q_tag[0];
  assign opa_value  = q_val[0];
  assign opb_is_tag = q_is_tag[1];
  assign opb_tag    = q_tag[1];
  assign opb_value  = q_val[1];
endmodule

// File: rtl/alias_map_chk.sv
module alias_map_chk #(
  parameter int NREG = 8,
  parameter int DW   = 32,
  parameter int RW   = 3,
  parameter int TW   = 2
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    iss_valid,
  input logic [RW-1:0]           iss_src_a,
  input logic [RW-1:0]           iss_dst,
  input logic [TW-1:0]           iss_tag,
  input logic                    bc_valid,
  input logic [TW-1:0]           bc_tag,
  input logic [DW-1:0]           bc_value,
  input logic                    res_valid,
  input logic                    opa_is_tag,
  input logic [DW-1:0]           opa_value,
  input logic [NREG-1:0]         map_vld,
  input logic [NREG-1:0][TW-1:0] map_tag,
  input logic [NREG-1:0][DW-1:0] rf_q
);
  assert_issue_maps_R4: assert property (@(posedge clk) disable iff (rst)
    iss_valid |=> (map_vld[$past(iss_dst)] && map_tag[$past(iss_dst)] == $past(iss_tag)));

  assert_res_follows_issue_R9: assert property (@(posedge clk) disable iff (rst)
    iss_valid |=> res_valid);

  assert_res_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !iss_valid |=> !res_valid);

  assert_bypass_R8: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && bc_valid && map_vld[iss_src_a] && map_tag[iss_src_a] == bc_tag)
    |=> (!opa_is_tag && opa_value == $past(bc_value)));

  for (genvar r = 0; r < NREG; r++) begin : g_r
    assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
      (bc_valid && map_vld[r] && map_tag[r] == bc_tag && !(iss_valid && iss_dst == RW'(r)))
      |=> !map_vld[r]);

    assert_write_R5: assert property (@(posedge clk) disable iff (rst)
      (bc_valid && map_vld[r] && map_tag[r] == bc_tag) |=> (rf_q[r] == $past(bc_value)));

    assert_no_stray_write_R6: assert property (@(posedge clk) disable iff (rst)
      !(bc_valid && map_vld[r] && map_tag[r] == bc_tag) |=> $stable(rf_q[r]));
  end
endmodule

bind alias_map alias_map_chk #(.NREG(NREG), .DW(DW), .RW(RW), .TW(TW)) u_chk (
  .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_src_a(iss_src_a),
  .iss_dst(iss_dst), .iss_tag(iss_tag), .bc_valid(bc_valid), .bc_tag(bc_tag),
  .bc_value(bc_value), .res_valid(res_valid), .opa_is_tag(opa_is_tag),
  .opa_value(opa_value), .map_vld(map_vld), .map_tag(map_tag), .rf_q(rf_q)
);

// File: tb/alias_map_bench.sv
`timescale 1ns/1ps
module alias_map_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        iss_valid = 1'b0;
  logic [2:0]  iss_src_a = '0, iss_src_b = '0, iss_dst = '0;
  logic [1:0]  iss_tag = '0;
  logic        bc_valid = 1'b0;
  logic [1:0]  bc_tag = '0;
  logic [31:0] bc_value = '0;
  logic        res_valid, opa_is_tag, opb_is_tag;
  logic [1:0]  opa_tag, opb_tag;
  logic [31:0] opa_value, opb_value;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  alias_map u_alias_map (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_src_a(iss_src_a),
    .iss_src_b(iss_src_b), .iss_dst(iss_dst), .iss_tag(iss_tag),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_value(bc_value),
    .res_valid(res_valid), .opa_is_tag(opa_is_tag), .opa_tag(opa_tag),
    .opa_value(opa_value), .opb_is_tag(opb_is_tag), .opb_tag(opb_tag),
    .opb_value(opb_value)
  );

  // scratch destination for probes: r7 with tag 3, tag 3 is never broadcast
  task automatic step(input bit iv, input int sa, input int sb, input int d, input int t,
                      input bit bv, input int bt, input logic [31:0] bval);
    @(negedge clk);
    iss_valid = iv; iss_src_a = 3'(sa); iss_src_b = 3'(sb); iss_dst = 3'(d); iss_tag = 2'(t);
    bc_valid = bv; bc_tag = 2'(bt); bc_value = bval;
    @(posedge clk);
    #1;
    iss_valid = 1'b0; bc_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic probe(input int sa, input int sb);
    step(1, sa, sb, 7, 3, 0, 0, 32'h0);
  endtask

  task automatic chk_op(input string req, input bit is_a, input bit et, input int etag,
                        input logic [31:0] ev);
    logic        at;
    logic [1:0]  atag;
    logic [31:0] av;
    at   = is_a ? opa_is_tag : opb_is_tag;
    atag = is_a ? opa_tag : opb_tag;
    av   = is_a ? opa_value : opb_value;
    n_chk++;
    if (!res_valid || at !== et || (et ? (atag !== 2'(etag)) : (av !== ev))) begin
      n_bad++;
      $display("FAIL %s op%s: got valid=%0b is_tag=%0b tag=%0d val=%h, exp is_tag=%0b tag=%0d val=%h",
               req, is_a ? "a" : "b", res_valid, at, atag, av, et, etag, ev);
    end
  endtask

  task automatic chk_bit(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b exp %0b", req, act, exp);
    end
  endtask

  task automatic t_reset;
    chk_bit("R1 res_valid in reset", res_valid, 1'b0);
    @(negedge clk); rst = 1'b0;
    chk_bit("R1 res_valid after reset", res_valid, 1'b0);
    probe(0, 5);
    chk_op("R1", 1, 0, 0, 32'h0);
    chk_op("R1", 0, 0, 0, 32'h0);
    step(0, 0, 0, 0, 0, 0, 0, 32'h0);
    chk_bit("R9 idle cycle", res_valid, 1'b0);
  endtask

  task automatic t_rename;
    step(1, 2, 2, 2, 1, 0, 0, 32'h0);       // r2 <- tag 1, reading r2 itself
    chk_bit("R9 issue result", res_valid, 1'b1);
    chk_op("R10 src equals dst", 1, 0, 0, 32'h0);
    probe(2, 0);
    chk_op("R4/R3 renamed src", 1, 1, 1, 32'h0);
    chk_op("R2 plain src", 0, 0, 0, 32'h0);
  endtask

  task automatic t_writeback;
    step(0, 0, 0, 0, 0, 1, 1, 32'hAAAA5555);
    probe(2, 6);
    chk_op("R5 value after broadcast", 1, 0, 0, 32'hAAAA5555);
    chk_op("R2 untouched reg", 0, 0, 0, 32'h0);
  endtask

  task automatic t_bypass;
    step(1, 0, 0, 1, 2, 0, 0, 32'h0);       // r1 <- tag 2
    step(1, 1, 2, 7, 3, 1, 2, 32'h00001234);
    chk_op("R8 bypass", 1, 0, 0, 32'h00001234);
    chk_op("R2 other src", 0, 0, 0, 32'hAAAA5555);
    probe(1, 1);
    chk_op("R5 cleared after bypass", 1, 0, 0, 32'h00001234);
  endtask

  task automatic t_collision;
    step(1, 0, 0, 3, 0, 0, 0, 32'h0);       // r3 <- tag 0
    step(1, 0, 0, 3, 2, 1, 0, 32'h0000BEEF); // re-issue r3 <- tag 2 with broadcast of tag 0
    probe(3, 0);
    chk_op("R7 issue wins", 1, 1, 2, 32'h0);
    step(0, 0, 0, 0, 0, 1, 2, 32'h0000CAFE);
    probe(3, 0);
    chk_op("R7 later producer", 1, 0, 0, 32'h0000CAFE);
  endtask

  task automatic t_stale;
    step(1, 0, 0, 4, 0, 0, 0, 32'h0);       // r4 <- tag 0
    step(1, 0, 0, 4, 1, 0, 0, 32'h0);       // r4 <- tag 1
    step(1, 4, 2, 7, 3, 1, 0, 32'hDEADDEAD); // stale tag 0 result
    chk_op("R6 no bypass on stale", 1, 1, 1, 32'h0);
    probe(4, 5);
    chk_op("R6 mapping kept", 1, 1, 1, 32'h0);
    chk_op("R6 r5 unwritten", 0, 0, 0, 32'h0);
    probe(2, 1);
    chk_op("R6 r2 unchanged", 1, 0, 0, 32'hAAAA5555);
    chk_op("R6 r1 unchanged", 0, 0, 0, 32'h00001234);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset;
    t_rename;
    t_writeback;
    t_bypass;
    t_collision;
    t_stale;
    done = 1;
    finish_run;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete, got hang exp completion");
      finish_run;
    end
  end
endmodule